// File: doc/BRIEF.md
# Memory-Side Transaction Status Tracker

This block sits between an on-chip network and a single memory bank. It accepts request messages from the network over a valid/ready input and places each one in a small table of transaction status entries. When every entry is occupied, new requests wait in a request queue and move into the table as entries free up. Each entry stores the requester's source node, its tag, the address, the write flag and the write data.

A bank-control part starts one memory access per cycle and steps each entry through its states. The memory port is a plain enable/address bank with a fixed read latency. The entry is marked complete one cycle before its read word leaves the bank, so the transmit part can choose the reply in the same cycle the data arrives. The transmit part picks the entry that completed earliest. It builds a reply holding the unchanged source and tag plus the read word, or a plain acknowledgement for a write. It puts the reply on a valid/ready output and returns the entry to idle.

Top module: `mem_txn_tracker`

## Requirements
- R1: After reset, `rsp_valid` and `mem_en` are 0 and `req_ready` is 1.
- R2: A request accepted in cycle `a` (`req_valid` and `req_ready` both high) when no other work is pending is captured into a free entry. The bank access starts in cycle `a+1`: `mem_en`=1, `mem_addr` = request address, `mem_we` = request write flag, and `mem_wdata` = request write data.
- R3: Each entry moves only along idle → read pending → bank activated → complete → idle, and it may stay in any of these states.
- R4: The bank returns the read word on `mem_rdata` in the `BANK_LAT`-th cycle after the cycle in which `mem_en` was high. An entry turns complete one cycle earlier. An uncontended request accepted in cycle `a` therefore shows `rsp_valid`=1 first in cycle `a+2+BANK_LAT`, which is cycle `a+5` with the defaults.
- R5: A read reply carries the request's source and tag unchanged, `rsp_write`=0, and `rsp_data` equal to the bank word at the request address at the time of the access.
- R6: A write stores `req_wdata` at the address in the bank. Its reply carries the source and tag, `rsp_write`=1 and `rsp_data`=0.
- R7: When all entries are busy, accepted requests wait in the queue. Replies then leave in the order the requests were accepted, the earliest-completed entry first.
- R8: `req_ready` is 0 only while the table and the queue are both full. With `rsp_ready` held low, exactly 1 + `N_ENTRIES` + `Q_DEPTH` requests (9 with the defaults) are accepted before `req_ready` drops.
- R9: While `rsp_valid`=1 and `rsp_ready`=0, the reply stays valid and its fields do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request message present |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_src | input | SRC_W | Requesting node identifier |
| req_tag | input | TAG_W | Requester's transaction tag |
| req_addr | input | ADDR_W | Bank word address |
| req_wdata | input | DATA_W | Write data |
| mem_en | output | 1 | Bank access start |
| mem_we | output | 1 | Bank access is a write |
| mem_addr | output | ADDR_W | Bank address |
| mem_wdata | output | DATA_W | Bank write data |
| mem_rdata | input | DATA_W | Bank read word, BANK_LAT cycles after the access |
| rsp_valid | output | 1 | Reply message present |
| rsp_ready | input | 1 | Network takes the reply |
| rsp_write | output | 1 | Reply is a write acknowledgement |
| rsp_src | output | SRC_W | Source node copied from the request |
| rsp_tag | output | TAG_W | Tag copied from the request |
| rsp_data | output | DATA_W | Read word, or 0 for a write |

## Verification
Two events can fall in the same cycle: the request queue taking a new request while it is full, and the queue handing its oldest request to an entry that has just been freed. The bench provokes this by holding the reply output stalled until 9 requests fill the table, the queue and the reply register. It keeps a tenth request waiting, then reopens the output. All ten replies must then arrive exactly once, in acceptance order, with the right data, while `req_ready` stays low for as long as both stores are full. A second collision is the data-arrival cycle: a read word is forwarded straight into the reply while another completed entry waits. Streaming twelve reads with a toggling `rsp_ready` provokes this case.

// File: rtl/mtt_pkg.sv
package mtt_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_PEND = 2'd1,
      ST_ACT  = 2'd2,
      ST_DONE = 2'd3
   } ent_state_e;
endpackage

// File: rtl/mtt_req_fifo.sv
module mtt_req_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("mtt_req_fifo: DEPTH must be at least 1");
      end
   endgenerate

   logic [W-1:0]  slot_q [DEPTH];
   logic [PW-1:0] rd_q, wr_q;
   logic [CW-1:0] cnt_q;

   assign empty = (cnt_q == '0);
   assign full  = (cnt_q == CW'(DEPTH));
   assign dout  = slot_q[rd_q];

   function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
      return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q  <= '0;
         wr_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push) begin
            slot_q[wr_q] <= din;
            wr_q         <= nxt(wr_q);
         end
         if (pop) rd_q <= nxt(rd_q);
         case ({push, pop})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end
endmodule

// File: rtl/mtt_first_set.sv
module mtt_first_set #(
   parameter int N     = 4,
   parameter int IDX_W = 2
) (
   input  logic [N-1:0]     vec,
   output logic             found,
   output logic [IDX_W-1:0] idx
);
   always_comb begin
      found = |vec;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) idx = IDX_W'(i);
      end
   end
endmodule

// File: rtl/mtt_age_pick.sv
module mtt_age_pick #(
   parameter int N     = 4,
   parameter int IDX_W = 2,
   parameter int SEQ_W = 3
) (
   input  logic [N-1:0]            elig,
   input  logic [N-1:0][SEQ_W-1:0] stamp,
   input  logic [SEQ_W-1:0]        now_seq,
   output logic                    found,
   output logic [IDX_W-1:0]        idx
);
   logic [SEQ_W-1:0] best_age;
   logic [SEQ_W-1:0] age;

   always_comb begin
      found    = 1'b0;
      idx      = '0;
      best_age = '0;
      age      = '0;
      for (int i = 0; i < N; i++) begin
         age = now_seq - stamp[i];
         if (elig[i] && (!found || age > best_age)) begin
            found    = 1'b1;
            idx      = IDX_W'(i);
            best_age = age;
         end
      end
   end
endmodule

// File: rtl/mem_txn_tracker.sv
module mem_txn_tracker
   import mtt_pkg::*;
#(
   parameter int N_ENTRIES = 4,
   parameter int Q_DEPTH   = 4,
   parameter int BANK_LAT  = 3,
   parameter int SRC_W     = 4,
   parameter int TAG_W     = 4,
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [SRC_W-1:0]  req_src,
   input  logic [TAG_W-1:0]  req_tag,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              mem_en,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              rsp_valid,
   input  logic              rsp_ready,
   output logic              rsp_write,
   output logic [SRC_W-1:0]  rsp_src,
   output logic [TAG_W-1:0]  rsp_tag,
   output logic [DATA_W-1:0] rsp_data
);
   localparam int IDX_W = $clog2(N_ENTRIES);
   localparam int SEQ_W = IDX_W + 1;
   localparam int CNT_W = $clog2(BANK_LAT);
   localparam int PKT_W = 1 + SRC_W + TAG_W + ADDR_W + DATA_W;

   generate
      if (N_ENTRIES < 2) begin : g_bad_entries
         $error("mem_txn_tracker: N_ENTRIES must be at least 2");
      end
      if (BANK_LAT < 3) begin : g_bad_lat
         $error("mem_txn_tracker: BANK_LAT must be at least 3");
      end
   endgenerate

   // entry table
   logic [N_ENTRIES-1:0][1:0]        st_q;
   logic [N_ENTRIES-1:0]             wr_q, dv_q;
   logic [N_ENTRIES-1:0][SRC_W-1:0]  src_q;
   logic [N_ENTRIES-1:0][TAG_W-1:0]  tag_q;
   logic [N_ENTRIES-1:0][ADDR_W-1:0] addr_q;
   logic [N_ENTRIES-1:0][DATA_W-1:0] data_q;
   logic [N_ENTRIES-1:0][CNT_W-1:0]  cnt_q;
   logic [N_ENTRIES-1:0][SEQ_W-1:0]  stamp_q;
   logic [SEQ_W-1:0]                 seq_q;

   logic [N_ENTRIES-1:0] idle_v, pend_v, fin_v, elig_v;
   logic                 arr0_vld, arr1_vld;
   logic [IDX_W-1:0]     arr0_idx, arr1_idx;

   always_comb begin
      for (int i = 0; i < N_ENTRIES; i++) begin
         idle_v[i] = (st_q[i] == ST_IDLE);
         pend_v[i] = (st_q[i] == ST_PEND);
         fin_v[i]  = (st_q[i] == ST_ACT) && (cnt_q[i] == '0);
         elig_v[i] = (st_q[i] == ST_DONE) &&
                     (dv_q[i] || (arr1_vld && arr1_idx == IDX_W'(i)));
      end
   end

   // allocation path: queue head has priority over a fresh request
   logic             has_free, q_empty, q_full, q_push, q_pop, alloc_en;
   logic [IDX_W-1:0] free_idx;
   logic [PKT_W-1:0] in_pkt, q_dout, alloc_pkt;

   mtt_first_set #(.N(N_ENTRIES), .IDX_W(IDX_W)) u_free (
      .vec(idle_v), .found(has_free), .idx(free_idx));

   assign in_pkt    = {req_write, req_src, req_tag, req_addr, req_wdata};
   assign req_ready = has_free || !q_full;
   assign alloc_en  = has_free && (!q_empty || req_valid);
   assign alloc_pkt = q_empty ? in_pkt : q_dout;
   assign q_pop     = has_free && !q_empty;
   assign q_push    = req_valid && req_ready && !(q_empty && has_free);

   mtt_req_fifo #(.W(PKT_W), .DEPTH(Q_DEPTH)) u_queue (
      .clk(clk), .rst_n(rst_n), .push(q_push), .din(in_pkt), .pop(q_pop),
      .dout(q_dout), .empty(q_empty), .full(q_full));

   // bank control: one access per cycle
   logic             iss_en, fin_any;
   logic [IDX_W-1:0] iss_idx, fin_idx;

   mtt_first_set #(.N(N_ENTRIES), .IDX_W(IDX_W)) u_issue (
      .vec(pend_v), .found(iss_en), .idx(iss_idx));
   mtt_first_set #(.N(N_ENTRIES), .IDX_W(IDX_W)) u_fin (
      .vec(fin_v), .found(fin_any), .idx(fin_idx));

   assign mem_en    = iss_en;
   assign mem_we    = wr_q[iss_idx];
   assign mem_addr  = addr_q[iss_idx];
   assign mem_wdata = data_q[iss_idx];

   // transmit: earliest-completed entry with its word present
   logic             tx_found, out_load;
   logic [IDX_W-1:0] tx_idx;

   mtt_age_pick #(.N(N_ENTRIES), .IDX_W(IDX_W), .SEQ_W(SEQ_W)) u_pick (
      .elig(elig_v), .stamp(stamp_q), .now_seq(seq_q),
      .found(tx_found), .idx(tx_idx));

   assign out_load = tx_found && (!rsp_valid || rsp_ready);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arr0_vld <= 1'b0;
         arr1_vld <= 1'b0;
         arr0_idx <= '0;
         arr1_idx <= '0;
         seq_q    <= '0;
      end else begin
         arr0_vld <= fin_any;
         arr0_idx <= fin_idx;
         arr1_vld <= arr0_vld;
         arr1_idx <= arr0_idx;
         if (fin_any) seq_q <= seq_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= '0;
         wr_q    <= '0;
         dv_q    <= '0;
         src_q   <= '0;
         tag_q   <= '0;
         addr_q  <= '0;
         data_q  <= '0;
         cnt_q   <= '0;
         stamp_q <= '0;
      end else begin
         for (int i = 0; i < N_ENTRIES; i++) begin
            case (st_q[i])
               ST_IDLE: if (alloc_en && free_idx == IDX_W'(i)) begin
                  {wr_q[i], src_q[i], tag_q[i], addr_q[i], data_q[i]} <= alloc_pkt;
                  dv_q[i] <= 1'b0;
                  st_q[i] <= ST_PEND;
               end
               ST_PEND: if (iss_en && iss_idx == IDX_W'(i)) begin
                  cnt_q[i] <= CNT_W'(BANK_LAT - 3);
                  st_q[i]  <= ST_ACT;
               end
               ST_ACT: if (cnt_q[i] == '0) begin
                  stamp_q[i] <= seq_q;
                  st_q[i]    <= ST_DONE;
               end else begin
                  cnt_q[i] <= cnt_q[i] - 1'b1;
               end
               default: if (out_load && tx_idx == IDX_W'(i)) begin
                  st_q[i] <= ST_IDLE;
               end else if (arr1_vld && arr1_idx == IDX_W'(i)) begin
                  dv_q[i] <= 1'b1;
                  if (!wr_q[i]) data_q[i] <= mem_rdata;
               end
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_write <= 1'b0;
         rsp_src   <= '0;
         rsp_tag   <= '0;
         rsp_data  <= '0;
      end else if (out_load) begin
         rsp_valid <= 1'b1;
         rsp_write <= wr_q[tx_idx];
         rsp_src   <= src_q[tx_idx];
         rsp_tag   <= tag_q[tx_idx];
         rsp_data  <= wr_q[tx_idx] ? '0 :
                      (dv_q[tx_idx] ? data_q[tx_idx] : mem_rdata);
      end else if (rsp_ready) begin
         rsp_valid <= 1'b0;
      end
   end
endmodule

// File: rtl/mtt_checker.sv
module mtt_checker #(
   parameter int N      = 4,
   parameter int SRC_W  = 4,
   parameter int TAG_W  = 4,
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic [N-1:0][1:0] st,
   input logic              req_ready,
   input logic              mem_en,
   input logic              rsp_valid,
   input logic              rsp_ready,
   input logic              rsp_write,
   input logic [SRC_W-1:0]  rsp_src,
   input logic [TAG_W-1:0]  rsp_tag,
   input logic [DATA_W-1:0] rsp_data
);
   logic [N-1:0] idle_m, pend_m;
   always_comb begin
      for (int i = 0; i < N; i++) begin
         idle_m[i] = (st[i] == 2'd0);
         pend_m[i] = (st[i] == 2'd1);
      end
   end

   genvar g;
   generate
      for (g = 0; g < N; g++) begin : g_ent
         a_r3_idle_next: assert property (@(posedge clk) disable iff (!rst_n)
            (st[g] == 2'd0) |=> (st[g] == 2'd0 || st[g] == 2'd1));
         a_r3_pend_next: assert property (@(posedge clk) disable iff (!rst_n)
            (st[g] == 2'd1) |=> (st[g] == 2'd1 || st[g] == 2'd2));
         a_r3_act_next: assert property (@(posedge clk) disable iff (!rst_n)
            (st[g] == 2'd2) |=> (st[g] == 2'd2 || st[g] == 2'd3));
         a_r3_done_next: assert property (@(posedge clk) disable iff (!rst_n)
            (st[g] == 2'd3) |=> (st[g] == 2'd3 || st[g] == 2'd0));
      end
   endgenerate

   a_r2_issue_from_pending: assert property (@(posedge clk) disable iff (!rst_n)
      mem_en |-> (pend_m != '0));

   a_r8_ready_low_only_full: assert property (@(posedge clk) disable iff (!rst_n)
      !req_ready |-> (idle_m == '0));

   a_r9_reply_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=>
         (rsp_valid && $stable(rsp_write) && $stable(rsp_src) &&
          $stable(rsp_tag) && $stable(rsp_data)));
endmodule

bind mem_txn_tracker mtt_checker #(
   .N(N_ENTRIES), .SRC_W(SRC_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .st(st_q), .req_ready(req_ready),
   .mem_en(mem_en), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
   .rsp_write(rsp_write), .rsp_src(rsp_src), .rsp_tag(rsp_tag),
   .rsp_data(rsp_data)
);

// File: tb/mem_txn_tracker_bench.sv
`timescale 1ns/100ps
module mem_txn_tracker_bench;
   localparam int LAT = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [3:0]  req_src = '0, req_tag = '0;
   logic [7:0]  req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic        req_ready;
   logic        mem_en, mem_we;
   logic [7:0]  mem_addr;
   logic [15:0] mem_wdata, mem_rdata;
   logic        rsp_valid, rsp_write;
   logic        rsp_ready = 1'b1;
   logic [3:0]  rsp_src, rsp_tag;
   logic [15:0] rsp_data;

   always #2.5 clk = ~clk;

   mem_txn_tracker u_mem_txn_tracker (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_src(req_src), .req_tag(req_tag),
      .req_addr(req_addr), .req_wdata(req_wdata), .mem_en(mem_en),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
      .rsp_write(rsp_write), .rsp_src(rsp_src), .rsp_tag(rsp_tag),
      .rsp_data(rsp_data));

   // bank model with fixed read latency
   logic [15:0] bank  [256];
   logic [15:0] shadow[256];
   logic [7:0]  pipe_a[LAT];
   initial begin
      for (int i = 0; i < 256; i++) begin
         bank[i]   = 16'hA000 ^ 16'(i * 37);
         shadow[i] = 16'hA000 ^ 16'(i * 37);
      end
      for (int i = 0; i < LAT; i++) pipe_a[i] = '0;
   end
   always @(posedge clk) begin
      if (mem_en && mem_we) bank[mem_addr] <= mem_wdata;
      pipe_a[0] <= mem_addr;
      for (int i = 1; i < LAT; i++) pipe_a[i] <= pipe_a[i-1];
   end
   assign mem_rdata = bank[pipe_a[LAT-1]];

   int checks = 0, fails = 0;
   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string what, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", what, act, exp);
      end
   endtask

   // scoreboard in acceptance order
   logic        e_wr  [256];
   logic [3:0]  e_src [256], e_tag[256];
   logic [15:0] e_dat [256];
   int wp = 0, rp = 0, acc_cyc = 0;
   logic        prev_stall = 1'b0;
   logic [36:0] prev_rsp = '0;

   always @(negedge clk) begin
      if (rst_n && req_valid && req_ready) begin
         e_wr[wp[7:0]]  = req_write;
         e_src[wp[7:0]] = req_src;
         e_tag[wp[7:0]] = req_tag;
         if (req_write) begin
            e_dat[wp[7:0]]   = 16'h0;
            shadow[req_addr] = req_wdata;
         end else begin
            e_dat[wp[7:0]] = shadow[req_addr];
         end
         acc_cyc = cyc;
         wp++;
      end
      if (rst_n && prev_stall)
         chk(rsp_valid && {rsp_write, rsp_src, rsp_tag, rsp_data} == prev_rsp,
             "R9 reply held while stalled", {rsp_valid, rsp_write, rsp_src, rsp_tag, rsp_data},
             {1'b1, prev_rsp});
      if (rst_n && rsp_valid && rsp_ready) begin
         chk(rp < wp, "R7 reply without request", rp, wp);
         chk({rsp_write, rsp_src, rsp_tag, rsp_data} ==
             {e_wr[rp[7:0]], e_src[rp[7:0]], e_tag[rp[7:0]], e_dat[rp[7:0]]},
             "R5 R6 R7 reply fields/order", {rsp_write, rsp_src, rsp_tag, rsp_data},
             {e_wr[rp[7:0]], e_src[rp[7:0]], e_tag[rp[7:0]], e_dat[rp[7:0]]});
         rp++;
      end
      prev_stall = rst_n && rsp_valid && !rsp_ready;
      prev_rsp   = {rsp_write, rsp_src, rsp_tag, rsp_data};
   end

   task automatic send(input logic w, input logic [3:0] s, input logic [3:0] t,
                       input logic [7:0] a, input logic [15:0] d);
      @(posedge clk) #1;
      req_valid = 1'b1; req_write = w; req_src = s; req_tag = t;
      req_addr = a; req_wdata = d;
      forever begin
         @(negedge clk);
         if (req_ready) break;
      end
   endtask

   task automatic stop_send();
      @(posedge clk) #1;
      req_valid = 1'b0;
   endtask

   task automatic drain(input string tag);
      for (int k = 0; k < 300 && rp != wp; k++) @(negedge clk);
      chk(rp == wp, tag, rp, wp);
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(rsp_valid == 1'b0, "R1 rsp_valid after reset", rsp_valid, 0);
      chk(mem_en == 1'b0, "R1 mem_en after reset", mem_en, 0);
      chk(req_ready == 1'b1, "R1 req_ready after reset", req_ready, 1);
   endtask

   task automatic t_single_latency();
      int k;
      send(1'b0, 4'h3, 4'h5, 8'h12, 16'h0);
      fork stop_send(); join_none
      @(negedge clk);
      chk(mem_en == 1'b1, "R2 bank start one cycle after accept", mem_en, 1);
      chk(mem_addr == 8'h12 && mem_we == 1'b0, "R2 bank address/write flag",
          {mem_we, mem_addr}, {1'b0, 8'h12});
      k = 1;
      while (!rsp_valid && k < 20) begin
         @(negedge clk);
         k++;
      end
      chk(k == 2 + LAT, "R4 reply latency", k, 2 + LAT);
      drain("R5 single read reply count");
   endtask

   task automatic t_write_read();
      int k;
      send(1'b1, 4'h9, 4'hA, 8'h40, 16'hBEEF);
      fork stop_send(); join_none
      @(negedge clk);
      chk(mem_en && mem_we && mem_addr == 8'h40 && mem_wdata == 16'hBEEF,
          "R6 bank write access", {mem_en, mem_we, mem_addr, mem_wdata},
          {1'b1, 1'b1, 8'h40, 16'hBEEF});
      k = 1;
      while (!rsp_valid && k < 20) begin
         @(negedge clk);
         k++;
      end
      chk(rsp_write == 1'b1 && rsp_data == 16'h0, "R6 write acknowledge",
          {rsp_write, rsp_data}, {1'b1, 16'h0});
      send(1'b0, 4'h2, 4'hB, 8'h40, 16'h0);
      stop_send();
      drain("R6 write then read-back replies");
   endtask

   task automatic t_fill_collision();
      int base;
      bit done = 0;
      base = wp;
      @(posedge clk) #1 rsp_ready = 1'b0;
      fork
         begin
            for (int j = 0; j < 10; j++)
               send(1'b0, 4'(j), 4'(j + 1), 8'(8'h80 + j * 3), 16'h0);
            stop_send();
            done = 1;
         end
      join_none
      repeat (40) @(negedge clk);
      chk(wp - base == 9, "R8 accepted count with output stalled", wp - base, 9);
      chk(req_ready == 1'b0, "R8 ready low when table and queue full", req_ready, 0);
      chk(rsp_valid == 1'b1, "R9 reply pending while stalled", rsp_valid, 1);
      @(posedge clk) #1 rsp_ready = 1'b1;
      for (int k = 0; k < 100 && !done; k++) @(negedge clk);
      chk(wp - base == 10, "R7 tenth request taken after release", wp - base, 10);
      drain("R7 all queued replies delivered");
   endtask

   task automatic t_stream();
      bit done = 0;
      fork
         begin
            for (int j = 0; j < 12; j++)
               send(1'b0, 4'(15 - j), 4'(j), 8'(j * 11 + 1), 16'h0);
            stop_send();
            done = 1;
         end
         begin
            for (int k = 0; k < 80; k++) begin
               @(posedge clk) #1 rsp_ready = (k % 3) != 0;
            end
            @(posedge clk) #1 rsp_ready = 1'b1;
         end
      join
      chk(done == 1'b1, "R7 stream fully accepted", done, 1);
      drain("R7 stream replies in order");
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_single_latency();
      t_write_read();
      t_fill_collision();
      t_stream();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule